// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a charge-redistribution successive-approximation converter. While idle it keeps the sampling switch closed and every capacitor plate tied to the analog input. The tracking interval after each conversion starts with a coarse charge phase of configurable length and then moves to a fine charge phase. A conversion command is accepted only during fine tracking. The block then opens the sampling switch, waits one hold cycle, and runs one trial per bit from the most significant bit down. In each trial it drives the plates only to the reference or to ground and reads a single comparator sign bit.

When the last trial ends the block closes the switch and returns the plates to the input. It raises a one-cycle done pulse and formats the result as straight binary, offset binary or two's complement. It then shifts the word out MSB first on a divided serial clock, framed by a data-valid signal. A mode input selects single-channel operation or alternation between two channels. The channel of each word is reported next to the serial stream.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Reset state and the idle state. `samp_closed`=1, `plate_ain`=1, `plate_ref`=0, `busy`=0 and `done`=0. `coarse`=1 for exactly COARSE_CYC cycles after reset is released, and `coarse`=0 (fine tracking) after that.
- R2: A `start` sampled during fine tracking gives a hold cycle: `samp_closed`=0, `busy`=1, `plate_ain` still 1 and `plate_ref`=0. `plate_ain` drops to 0 in the next cycle. A `start` sampled during coarse tracking is ignored: `busy` stays 0 and `samp_closed` stays 1.
- R3: Each trial lasts SETTLE_CYC+1 cycles. On the first cycle `plate_ref` shows the bits already kept, plus the bit under test set to 1 (1 = reference, 0 = ground), with all lower bits 0. The bits stay stable until the comparator is sampled on the last cycle. `cmp_hi`=1 (the plate code overshoots the held input) drops the bit, and `cmp_hi`=0 keeps it.
- R4: The result is the largest code not above the input held when the switch opened. A change of the analog input after the switch opens has no effect on the result.
- R5: `done` rises 2+NBITS*(SETTLE_CYC+1) cycles after the cycle in which `start` was driven, and lasts one cycle. In that cycle `samp_closed`=1, `plate_ain`=1 and `coarse`=1. Coarse tracking lasts COARSE_CYC cycles, counting the `done` cycle.
- R6: With `dual_mode`=1, `chan_sel` toggles after each conversion. With `dual_mode`=0 it is 0 after each conversion. `chan_sel` is stable while the switch is open. `sd_chan` gives the channel that was converted for the word being shifted (0 = first channel, 1 = second channel).
- R7: The coding is as follows. With `bipolar`=0 the word is the straight binary result, whatever `twos_sel` is. With `bipolar`=1 and `twos_sel`=0 the word is the unchanged offset-binary result. With `bipolar`=1 and `twos_sel`=1 the word is the result with bit NBITS-1 inverted.
- R8: `sdv` rises in the cycle after `done` and stays high for 2*NBITS cycles. Each bit lasts two cycles: `sclk` is 0 on the first cycle and 1 on the second. `sdata` is stable across each bit, and the bits come MSB first.
- R9: A `start` that arrives while `busy`=1 is ignored. The `done` latency and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion command |
| dual_mode | input | 1 | 1 = alternate between two channels, 0 = single channel |
| bipolar | input | 1 | 1 = bipolar input range |
| twos_sel | input | 1 | 1 = two's-complement coding in bipolar range |
| cmp_hi | input | 1 | Comparator: 1 = the plate code overshoots the held input |
| plate_ref | output | NBITS | Per-bit plate select during trials: 1 = reference, 0 = ground |
| plate_ain | output | 1 | 1 = all plates tied to the analog input |
| samp_closed | output | 1 | 1 = sampling switch closed (tracking) |
| coarse | output | 1 | 1 = coarse charge phase, 0 = fine charge phase or converting |
| chan_sel | output | 1 | Channel being tracked or converted |
| busy | output | 1 | Hold or trial phase in progress |
| done | output | 1 | One-cycle pulse at the end of a conversion |
| sdata | output | 1 | Serial data, MSB first |
| sclk | output | 1 | Serial clock, rising edge in the middle of each bit |
| sdv | output | 1 | Serial word valid frame |
| sd_chan | output | 1 | Channel of the word being shifted |

## Verification
The hardest case to reach is a change in the analog input after the hold point. The ports cannot show that the held charge is used and not the live input. The bench therefore models the held charge itself: it latches the channel's input on the falling edge of `samp_closed`, and the comparator compares the plate code against that latched value. It then changes the live input in the middle of the trials and checks that the serial word still matches the value that was held. A second hard case is a repeated command during the trials, which the bench injects at a chosen cycle. It then checks that the `done` latency is unchanged.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;

   typedef enum logic [1:0] {
      ST_COARSE = 2'd0,
      ST_FINE   = 2'd1,
      ST_HOLD   = 2'd2,
      ST_TRIAL  = 2'd3
   } sar_state_e;

endpackage

// File: rtl/sar_trial_engine.sv
`timescale 1ns/1ps
module sar_trial_engine #(
   parameter int NBITS      = 16,
   parameter int SETTLE_CYC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] plate_code,
   output logic [NBITS-1:0] result,
   output logic             fin,
   output logic             fin_q
);
   localparam int SC_W = $clog2(SETTLE_CYC + 1);

   logic [NBITS-1:0] sar;
   logic [NBITS-1:0] trial;
   logic [SC_W-1:0]  scnt;
   logic             smp;

   assign smp    = run && (scnt == SC_W'(SETTLE_CYC));
   assign fin    = smp && trial[0];
   assign result = sar;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sar   <= '0;
         trial <= '0;
         scnt  <= '0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= fin;
         if (load) begin
            sar   <= '0;
            trial <= {1'b1, {(NBITS-1){1'b0}}};
            scnt  <= '0;
         end else if (run) begin
            if (smp) begin
               scnt  <= '0;
               sar   <= sar | (cmp_hi ? '0 : trial);
               trial <= trial >> 1;
            end else begin
               scnt <= scnt + 1'b1;
            end
         end
      end
   end

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_plate
         assign plate_code[i] = run & (sar[i] | trial[i]);
      end
   endgenerate

   // R3
   plate_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && scnt != '0) |-> $stable(plate_code));

   // R3
   drop_on_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && cmp_hi) |=> ((sar & $past(trial)) == '0));

endmodule

// File: rtl/sar_out_coder.sv
`timescale 1ns/1ps
module sar_out_coder #(
   parameter int NBITS = 16
) (
   input  logic [NBITS-1:0] bin,
   input  logic             bipolar,
   input  logic             twos_sel,
   output logic [NBITS-1:0] word
);
   logic flip_msb;

   assign flip_msb = bipolar & twos_sel;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         if (i == NBITS - 1) begin : g_msb
            assign word[i] = bin[i] ^ flip_msb;
         end else begin : g_low
            assign word[i] = bin[i];
         end
      end
   endgenerate

endmodule

// File: rtl/sar_serializer.sv
`timescale 1ns/1ps
module sar_serializer #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] word,
   input  logic             chan_in,
   output logic             sdata,
   output logic             sclk,
   output logic             sdv,
   output logic             sd_chan
);
   localparam int BC_W = $clog2(NBITS + 1);

   logic [NBITS-1:0] shreg;
   logic [BC_W-1:0]  bcnt;
   logic             phase;
   logic             active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         bcnt    <= '0;
         phase   <= 1'b0;
         active  <= 1'b0;
         sd_chan <= 1'b0;
      end else if (load) begin
         shreg   <= word;
         bcnt    <= BC_W'(NBITS);
         phase   <= 1'b0;
         active  <= 1'b1;
         sd_chan <= chan_in;
      end else if (active) begin
         phase <= ~phase;
         if (phase) begin
            shreg <= shreg << 1;
            bcnt  <= bcnt - 1'b1;
            if (bcnt == BC_W'(1)) active <= 1'b0;
         end
      end
   end

   assign sdata = active & shreg[NBITS-1];
   assign sclk  = active & phase;
   assign sdv   = active;

   // R8
   sdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdv && sclk) |-> $stable(sdata));

   // R8
   frame_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdv) |-> !sclk);

endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl #(
   parameter int NBITS      = 16,
   parameter int SETTLE_CYC = 1,
   parameter int COARSE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dual_mode,
   input  logic             bipolar,
   input  logic             twos_sel,
   input  logic             cmp_hi,
   output logic [NBITS-1:0] plate_ref,
   output logic             plate_ain,
   output logic             samp_closed,
   output logic             coarse,
   output logic             chan_sel,
   output logic             busy,
   output logic             done,
   output logic             sdata,
   output logic             sclk,
   output logic             sdv,
   output logic             sd_chan
);
   import sar_pkg::*;

   localparam int TC_W = $clog2(COARSE_CYC + 1);

   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("sar_conv_ctrl: NBITS must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("sar_conv_ctrl: SETTLE_CYC must be at least 1 so a conversion outlasts a serial word");
      end
      if (COARSE_CYC < 1) begin : g_bad_coarse
         $error("sar_conv_ctrl: COARSE_CYC must be at least 1");
      end
   endgenerate

   sar_state_e       state;
   logic [TC_W-1:0]  tcnt;
   logic             conv_chan;
   logic             fin;
   logic             fin_q;
   logic [NBITS-1:0] result;
   logic [NBITS-1:0] coded;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_COARSE;
         tcnt      <= '0;
         chan_sel  <= 1'b0;
         conv_chan <= 1'b0;
      end else begin
         unique case (state)
            ST_COARSE: begin
               if (tcnt == TC_W'(COARSE_CYC - 1)) begin
                  state <= ST_FINE;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_FINE:  if (start) state <= ST_HOLD;
            ST_HOLD:  state <= ST_TRIAL;
            ST_TRIAL: begin
               if (fin) begin
                  state     <= ST_COARSE;
                  tcnt      <= '0;
                  conv_chan <= chan_sel;
                  chan_sel  <= dual_mode ? ~chan_sel : 1'b0;
               end
            end
            default: state <= ST_COARSE;
         endcase
      end
   end

   assign samp_closed = (state == ST_COARSE) || (state == ST_FINE);
   assign plate_ain   = (state != ST_TRIAL);
   assign coarse      = (state == ST_COARSE);
   assign busy        = (state == ST_HOLD) || (state == ST_TRIAL);
   assign done        = fin_q;

   sar_trial_engine #(
      .NBITS      (NBITS),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (state == ST_HOLD),
      .run        (state == ST_TRIAL),
      .cmp_hi     (cmp_hi),
      .plate_code (plate_ref),
      .result     (result),
      .fin        (fin),
      .fin_q      (fin_q)
   );

   sar_out_coder #(
      .NBITS (NBITS)
   ) u_coder (
      .bin      (result),
      .bipolar  (bipolar),
      .twos_sel (twos_sel),
      .word     (coded)
   );

   sar_serializer #(
      .NBITS (NBITS)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fin_q),
      .word    (coded),
      .chan_in (conv_chan),
      .sdata   (sdata),
      .sclk    (sclk),
      .sdv     (sdv),
      .sd_chan (sd_chan)
   );

   // R2
   hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(samp_closed) |-> (plate_ain && plate_ref == '0));

   // R5
   done_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (samp_closed && plate_ain && coarse));

   // R6
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_closed |-> $stable(chan_sel));

   // R1
   no_coarse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!coarse && !samp_closed));

endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
   localparam int N   = 16;
   localparam int S   = 1;
   localparam int CC  = 4;
   localparam int LAT = 2 + N * (S + 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         dual_mode = 1'b0;
   logic         bipolar = 1'b0;
   logic         twos_sel = 1'b0;
   logic         cmp_hi;
   logic [N-1:0] plate_ref;
   logic         plate_ain, samp_closed, coarse, chan_sel, busy, done;
   logic         sdata, sclk, sdv, sd_chan;

   logic [N-1:0] vin0 = '0;
   logic [N-1:0] vin1 = '0;
   logic [N-1:0] vheld = '0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sar_conv_ctrl #(.NBITS(N), .SETTLE_CYC(S), .COARSE_CYC(CC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dual_mode(dual_mode),
      .bipolar(bipolar), .twos_sel(twos_sel), .cmp_hi(cmp_hi),
      .plate_ref(plate_ref), .plate_ain(plate_ain), .samp_closed(samp_closed),
      .coarse(coarse), .chan_sel(chan_sel), .busy(busy), .done(done),
      .sdata(sdata), .sclk(sclk), .sdv(sdv), .sd_chan(sd_chan)
   );

   // held charge model: input latched when the sampling switch opens
   always @(negedge samp_closed) vheld = chan_sel ? vin1 : vin0;
   assign cmp_hi = (plate_ref > vheld);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_word(input logic [N-1:0] v, input logic bip, input logic tw);
      return (bip && tw) ? {~v[N-1], v[N-2:0]} : v;
   endfunction

   // poke_kind: 0 none, 1 change live inputs, 2 extra start pulse
   task automatic convert(input int poke_at, input int poke_kind,
                          output logic [N-1:0] word, output logic ch,
                          output int lat, output int nsdv, output bit first_low);
      int ncoarse;
      while (coarse) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         if (lat == poke_at && poke_kind == 1) begin
            vin0 = ~vin0;
            vin1 = ~vin1;
         end
         if (lat == poke_at && poke_kind == 2) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      // R5 state at the done pulse
      chk(samp_closed && plate_ain && coarse, "R5 tracking at done",
          {samp_closed, plate_ain, coarse}, 3'b111);
      word = '0;
      ch = 1'b0;
      nsdv = 0;
      first_low = 1'b0;
      ncoarse = 1;
      for (int c = 0; c < 2 * N + 2; c++) begin
         @(negedge clk);
         if (coarse) ncoarse++;
         if (sdv) begin
            if (nsdv == 0) first_low = !sclk;
            nsdv++;
            ch = sd_chan;
            if (sclk) word = {word[N-2:0], sdata};
         end
      end
      chk(ncoarse == CC, "R5 coarse length", ncoarse, CC);
   endtask

   task automatic t_reset();
      int n;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(samp_closed && plate_ain && !busy && !done && !sdv, "R1 idle outputs",
          {samp_closed, plate_ain, busy, done, sdv}, 5'b11000);
      chk(plate_ref == '0, "R1 plates cleared", plate_ref, 0);
      n = 0;
      while (coarse && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(n == CC, "R1 coarse after reset", n, CC);
      chk(samp_closed && !coarse && !busy, "R1 fine tracking", {samp_closed, coarse, busy}, 3'b100);
   endtask

   task automatic t_trial_order();
      vin0 = 16'h1234;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // lat 1: hold cycle
      chk(!samp_closed && plate_ain && busy && plate_ref == '0, "R2 hold cycle",
          {samp_closed, plate_ain, busy}, 3'b011);
      @(negedge clk);
      chk(!plate_ain && plate_ref == 16'h8000, "R3 first trial MSB", plate_ref, 16'h8000);
      @(negedge clk);
      chk(plate_ref == 16'h8000, "R3 settle keeps plates", plate_ref, 16'h8000);
      @(negedge clk);
      chk(plate_ref == 16'h4000, "R3 overshoot drops bit", plate_ref, 16'h4000);
      repeat (6) @(negedge clk);
      chk(plate_ref == 16'h1800, "R3 kept bit stays", plate_ref, 16'h1800);
      while (!done) @(negedge clk);
      // coarse phase: a start here must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(!busy && samp_closed, "R2 start in coarse ignored", {busy, samp_closed}, 2'b01);
      repeat (2 * N + 4) @(negedge clk);
      chk(!busy && samp_closed && !coarse, "R2 still idle", {busy, samp_closed, coarse}, 3'b010);
   endtask

   task automatic run_code(input logic [N-1:0] v, input logic bip, input logic tw);
      logic [N-1:0] w;
      logic ch;
      int lat, nsdv;
      bit fl;
      vin0 = v;
      bipolar = bip;
      twos_sel = tw;
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(w == exp_word(v, bip, tw), "R4 R7 coded word", w, exp_word(v, bip, tw));
      chk(lat == LAT, "R5 done latency", lat, LAT);
      chk(nsdv == 2 * N && fl, "R8 serial frame", nsdv, 2 * N);
   endtask

   task automatic t_codes();
      run_code(16'h1234, 1'b0, 1'b1);
      run_code(16'hFFFF, 1'b0, 1'b0);
      run_code(16'h0000, 1'b1, 1'b1);
      run_code(16'h8000, 1'b1, 1'b1);
      run_code(16'h7FFF, 1'b1, 1'b1);
      run_code(16'hA5C3, 1'b1, 1'b0);
      bipolar = 1'b0;
      twos_sel = 1'b0;
   endtask

   task automatic t_hold_ignore();
      logic [N-1:0] w;
      logic ch;
      int lat, nsdv;
      bit fl;
      vin0 = 16'h3C3C;
      convert(10, 1, w, ch, lat, nsdv, fl);
      chk(w == 16'h3C3C, "R4 input ignored after hold", w, 16'h3C3C);
   endtask

   task automatic t_busy_start();
      logic [N-1:0] w;
      logic ch;
      int lat, nsdv;
      bit fl;
      vin0 = 16'h0F0F;
      convert(12, 2, w, ch, lat, nsdv, fl);
      chk(lat == LAT, "R9 latency with extra start", lat, LAT);
      chk(w == 16'h0F0F, "R9 result with extra start", w, 16'h0F0F);
      repeat (4) @(negedge clk);
      chk(!busy, "R9 no second conversion", busy, 0);
   endtask

   task automatic t_dual();
      logic [N-1:0] w;
      logic ch;
      int lat, nsdv;
      bit fl;
      vin0 = 16'h1111;
      vin1 = 16'h2222;
      dual_mode = 1'b1;
      chk(chan_sel == 1'b0, "R6 start on first channel", chan_sel, 0);
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(ch == 1'b0 && w == 16'h1111, "R6 first channel word", {ch, w}, {1'b0, 16'h1111});
      chk(chan_sel == 1'b1, "R6 toggle after conversion", chan_sel, 1);
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(ch == 1'b1 && w == 16'h2222, "R6 second channel word", {ch, w}, {1'b1, 16'h2222});
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(ch == 1'b0 && w == 16'h1111, "R6 alternation back", {ch, w}, {1'b0, 16'h1111});
      dual_mode = 1'b0;
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(ch == 1'b1 && w == 16'h2222, "R6 pending channel in single", {ch, w}, {1'b1, 16'h2222});
      chk(chan_sel == 1'b0, "R6 single mode returns to 0", chan_sel, 0);
      convert(0, 0, w, ch, lat, nsdv, fl);
      chk(ch == 1'b0 && chan_sel == 1'b0, "R6 single mode stays", {ch, chan_sel}, 2'b00);
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_trial_order();
      t_codes();
      t_hold_ignore();
      t_busy_start();
      t_dual();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule